// File: doc/BRIEF.md
# Vertical 3-to-5 Interpolating Line Scaler

This block stretches a television-rate picture vertically so that it fills a taller flat panel. For every three source lines it receives, it emits five output lines. Each output pixel is a fixed blend of the pixels in the same column of the three stored source lines. The blend is always a sum of four colour samples, so changing which source line feeds each of the four terms sets the weights. With the default settings, 288 visible source lines become exactly 480 panel lines.

Source pixels arrive one per clock as 8-bit packed colour, with a marker on the last pixel of each line and another on the first pixel of a frame. The block writes the three lines of a group into three line buffers in turn. Once the third line of a group is complete, it plays back five output line periods. Each period has a line-sync pulse, a data-enable window and a 15-bit pixel stream. After the final image line of a frame, it issues a few blank line-sync periods so that the panel's frame parity stays consistent. Frame sync is raised with the line-sync pulse of the first image line of every frame.

Top module: `vscale_3to5`

## Requirements
- R1: While reset is held and directly after it, out_de, out_hsync and out_vsync are low, and no pixel is produced until a full group of three source lines has been stored.
- R2: A source pixel carries red in bits [2:0], green in bits [5:3] and blue in bits [7:6]. in_last marks the last pixel of a line. The line that completes the third buffer of a group starts playback of that group.
- R3: A group with source lines a, b, c yields five output lines, in this order, formed from four column samples each: (a,a,a,a), (a,a,a,b), (b,b,b,b), (b,b,c,c), (c,c,c,c).
- R4: Each colour component is summed separately over the four samples, plus a rounding constant of 1, into a 5-bit field. The output pixel has red in bits [4:0], green in [9:5] and blue in [14:10].
- R5: Every output line period lasts HS_LEN+WIDTH+H_BLANK clocks. out_hsync is high for its first HS_LEN clocks. out_de rises exactly HS_LEN+3 clocks after out_hsync rises (the mixer latency is three clocks) and stays high for exactly WIDTH clocks, never overlapping out_hsync.
- R6: out_vsync is high only during the line-sync pulse of the first image line of a frame. Each frame holds OUT_LINES image lines.
- R7: After the last image line of a frame, PAD_LINES further line periods follow, each with an out_hsync pulse and with out_de and out_vsync low. The next frame sync therefore comes OUT_LINES+PAD_LINES line pulses after the previous one.
- R8: A valid pixel with in_sof high is written as column 0 of the first buffer of a new group. Any partly stored group is discarded and produces no output.
- R9: At the extremes, an all-zero source gives output 0x0421 (every field 1) and an all-ones source gives 0x37BD (fields 29, 29, 13).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source pixel present |
| in_pix | input | 8 | Packed source pixel (R 3, G 3, B 2 bits) |
| in_last | input | 1 | Last pixel of a source line |
| in_sof | input | 1 | First pixel of a source frame |
| out_de | output | 1 | Output data enable |
| out_pix | output | 15 | Blended output pixel (5 bits per component) |
| out_hsync | output | 1 | Output line sync |
| out_vsync | output | 1 | Output frame sync |

## Verification
The hardest situation to reach from the ports is the frame boundary. There, the last group of a frame must switch into blank padding periods, and the next group must bring frame sync back exactly with its first line-sync pulse. The stimulus runs several complete frames back to back and counts line pulses between frame syncs. It also starts one frame with a stray partial line under a start-of-frame marker, to show that the partial group is dropped without disturbing the frame count. Extreme all-zero and all-ones groups hit the rounding edges of every field.

// File: rtl/vscale_pkg.sv
package vscale_pkg;

  typedef enum logic [1:0] {
    SRC_A = 2'd0,
    SRC_B = 2'd1,
    SRC_C = 2'd2
  } src_e;

  // Which stored line feeds term j (0..3) of output line k (0..4).
  function automatic src_e tap_src(input logic [2:0] k, input int j);
    case (k)
      3'd0:    return SRC_A;
      3'd1:    return (j == 3) ? SRC_B : SRC_A;
      3'd2:    return SRC_B;
      3'd3:    return (j >= 2) ? SRC_C : SRC_B;
      default: return SRC_C;
    endcase
  endfunction

  // Component c of a packed pixel, zero-extended to 3 bits (0 red, 1 green, 2 blue).
  function automatic logic [2:0] field(input logic [7:0] p, input int c);
    case (c)
      0:       return p[2:0];
      1:       return p[5:3];
      default: return {1'b0, p[7:6]};
    endcase
  endfunction

endpackage

// File: rtl/vs_line_store.sv
module vs_line_store #(
  parameter  int WIDTH = 16,
  localparam int XW    = $clog2(WIDTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_pix,
  input  logic               in_last,
  input  logic               in_sof,
  input  logic [XW-1:0]      rd_x,
  output logic [2:0][7:0]    rd_pix,
  output logic               group_ready
);
  localparam logic [XW-1:0] X_LAST = XW'(WIDTH - 1);

  logic [1:0]    wbuf, wbuf_eff;
  logic [XW-1:0] wx, wx_eff;

  assign wbuf_eff = in_sof ? 2'd0 : wbuf;
  assign wx_eff   = in_sof ? '0 : wx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbuf        <= 2'd0;
      wx          <= '0;
      group_ready <= 1'b0;
    end else begin
      group_ready <= 1'b0;
      if (in_valid) begin
        if (in_last) begin
          wx <= '0;
          if (wbuf_eff == 2'd2) begin
            wbuf        <= 2'd0;
            group_ready <= 1'b1;
          end else begin
            wbuf <= wbuf_eff + 2'd1;
          end
        end else begin
          wbuf <= wbuf_eff;
          wx   <= (wx_eff == X_LAST) ? wx_eff : wx_eff + 1'b1;
        end
      end
    end
  end

  for (genvar gb = 0; gb < 3; gb++) begin : g_buf
    logic [7:0] mem [WIDTH];
    always_ff @(posedge clk) begin
      if (in_valid && wbuf_eff == 2'(gb)) mem[wx_eff] <= in_pix;
    end
    assign rd_pix[gb] = mem[rd_x];
  end

  // R2: playback request only follows a completed line
  a_r2_group_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    group_ready |-> $past(in_valid && in_last));

endmodule

// File: rtl/vs_mix_pipe.sv
module vs_mix_pipe
  import vscale_pkg::*;
(
  input  logic            clk,
  input  logic [3:0][7:0] op,
  output logic [14:0]     mix
);
  logic [7:0] c_q1, d_q1, d_q2;

  always_ff @(posedge clk) begin
    c_q1 <= op[2];
    d_q1 <= op[3];
    d_q2 <= d_q1;
  end

  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic [4:0] s1, s2, s3;
    always_ff @(posedge clk) begin
      s1 <= 5'(field(op[0], c)) + 5'(field(op[1], c));
      s2 <= s1 + 5'(field(c_q1, c));
      s3 <= s2 + 5'(field(d_q2, c)) + 5'd1;
    end
    assign mix[5*c +: 5] = s3;
  end

endmodule

// File: rtl/vs_scan_seq.sv
module vs_scan_seq #(
  parameter  int WIDTH     = 16,
  parameter  int HS_LEN    = 4,
  parameter  int H_BLANK   = 8,
  parameter  int OUT_LINES = 480,
  parameter  int PAD_LINES = 2,
  localparam int H_TOTAL   = HS_LEN + WIDTH + H_BLANK,
  localparam int HW        = $clog2(H_TOTAL),
  localparam int XW        = $clog2(WIDTH),
  localparam int FW        = $clog2(OUT_LINES),
  localparam int PW        = $clog2(PAD_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          hsync,
  output logic          vsync,
  output logic          rd_en,
  output logic [XW-1:0] rd_x,
  output logic [2:0]    line_k
);
  localparam logic [HW-1:0] H_LAST   = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT    = HW'(HS_LEN);
  localparam logic [HW-1:0] H_ACTEND = HW'(HS_LEN + WIDTH);
  localparam logic [FW-1:0] FL_LAST  = FW'(OUT_LINES - 1);
  localparam logic [PW-1:0] PAD_LAST = PW'(PAD_LINES - 1);

  logic [HW-1:0] h;
  logic [FW-1:0] fl;
  logic [PW-1:0] padcnt;
  logic          in_pad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      h      <= '0;
      line_k <= 3'd0;
      fl     <= '0;
      in_pad <= 1'b0;
      padcnt <= '0;
    end else if (!busy) begin
      busy   <= start;
      h      <= '0;
      line_k <= 3'd0;
      in_pad <= 1'b0;
      padcnt <= '0;
    end else if (h != H_LAST) begin
      h <= h + 1'b1;
    end else begin
      h <= '0;
      if (in_pad) begin
        if (padcnt == PAD_LAST) begin
          busy   <= 1'b0;
          in_pad <= 1'b0;
        end else begin
          padcnt <= padcnt + 1'b1;
        end
      end else begin
        fl <= (fl == FL_LAST) ? '0 : fl + 1'b1;
        if (line_k == 3'd4) begin
          line_k <= 3'd0;
          if (fl == FL_LAST) begin
            in_pad <= 1'b1;
            padcnt <= '0;
          end else begin
            busy <= 1'b0;
          end
        end else begin
          line_k <= line_k + 3'd1;
        end
      end
    end
  end

  assign hsync = busy && (h < H_ACT);
  assign vsync = hsync && !in_pad && (fl == '0);
  assign rd_en = busy && !in_pad && (h >= H_ACT) && (h < H_ACTEND);
  assign rd_x  = XW'(h - H_ACT);

  // R3: the line selector stays within the five-line pattern
  a_r3_line_index: assert property (@(posedge clk) disable iff (!rst_n)
    line_k <= 3'd4);

endmodule

// File: rtl/vscale_3to5.sv
module vscale_3to5
  import vscale_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int HS_LEN    = 4,
  parameter int H_BLANK   = 8,
  parameter int OUT_LINES = 480,
  parameter int PAD_LINES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_pix,
  input  logic        in_last,
  input  logic        in_sof,
  output logic        out_de,
  output logic [14:0] out_pix,
  output logic        out_hsync,
  output logic        out_vsync
);
  localparam int XW        = $clog2(WIDTH);
  localparam int MIX_DELAY = 3;

  logic [XW-1:0]   rd_x;
  logic [2:0][7:0] rd_pix;
  logic [3:0][7:0] op;
  logic [2:0]      line_k;
  logic            group_ready, pending, seq_busy, rd_en;
  logic [MIX_DELAY-1:0] de_q;

  vs_line_store #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_last(in_last), .in_sof(in_sof), .rd_x(rd_x), .rd_pix(rd_pix),
    .group_ready(group_ready)
  );

  vs_scan_seq #(
    .WIDTH(WIDTH), .HS_LEN(HS_LEN), .H_BLANK(H_BLANK),
    .OUT_LINES(OUT_LINES), .PAD_LINES(PAD_LINES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(pending), .busy(seq_busy),
    .hsync(out_hsync), .vsync(out_vsync), .rd_en(rd_en), .rd_x(rd_x),
    .line_k(line_k)
  );

  always_comb begin
    for (int j = 0; j < 4; j++) op[j] = rd_pix[tap_src(line_k, j)];
  end

  vs_mix_pipe u_mix (.clk(clk), .op(op), .mix(out_pix));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      de_q    <= '0;
    end else begin
      if (group_ready)    pending <= 1'b1;
      else if (!seq_busy) pending <= 1'b0;
      de_q <= {de_q[MIX_DELAY-2:0], rd_en};
    end
  end

  assign out_de = de_q[MIX_DELAY-1];

  // R3: playback starts only for a stored group
  a_r3_start_needs_group: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> $past(pending));

  // R5: delayed data window never overlaps line sync
  a_r5_de_clear_of_sync: assert property (@(posedge clk) disable iff (!rst_n)
    out_de |-> !out_hsync);

  // R4: each blended field within its sum range
  a_r4_field_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_de |-> (out_pix[4:0] >= 5'd1 && out_pix[4:0] <= 5'd29 &&
                out_pix[9:5] >= 5'd1 && out_pix[9:5] <= 5'd29 &&
                out_pix[14:10] >= 5'd1 && out_pix[14:10] <= 5'd13));

  // R6: frame sync begins a fresh group, never mid-playback
  a_r6_vsync_fresh_group: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vsync) |-> $past(!seq_busy));

endmodule

// File: tb/test_vscale_3to5.sv
`timescale 1ns/1ps
module test_vscale_3to5;
  localparam int W  = 8;
  localparam int HS = 2;
  localparam int HB = 4;
  localparam int OL = 10;
  localparam int PL = 2;
  localparam int HT = HS + W + HB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_sof = 1'b0;
  logic [7:0] in_pix = '0;
  logic out_de, out_hsync, out_vsync;
  logic [14:0] out_pix;

  always #2.5 clk = ~clk;

  vscale_3to5 #(.WIDTH(W), .HS_LEN(HS), .H_BLANK(HB), .OUT_LINES(OL), .PAD_LINES(PL))
    i_vscale_3to5 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
      .in_last(in_last), .in_sof(in_sof), .out_de(out_de), .out_pix(out_pix),
      .out_hsync(out_hsync), .out_vsync(out_vsync));

  int checks = 0, fails = 0;
  logic [14:0] exp_q[$];
  logic [7:0] src [3][W];
  bit mon_on = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // R3/R4 reference: weights per output line on (a,b,c), plus 1
  function automatic logic [14:0] ref_pix(input int k, input logic [7:0] a, b, c);
    int wa, wb, wc, va, vb, vc;
    logic [14:0] r;
    case (k)
      0: begin wa = 4; wb = 0; wc = 0; end
      1: begin wa = 3; wb = 1; wc = 0; end
      2: begin wa = 0; wb = 4; wc = 0; end
      3: begin wa = 0; wb = 2; wc = 2; end
      default: begin wa = 0; wb = 0; wc = 4; end
    endcase
    r = '0;
    for (int comp = 0; comp < 3; comp++) begin
      int sh, mk;
      sh = comp * 3;
      mk = (comp == 2) ? 3 : 7;
      va = (int'(a) >> sh) & mk;
      vb = (int'(b) >> sh) & mk;
      vc = (int'(c) >> sh) & mk;
      r[5*comp +: 5] = 5'(wa*va + wb*vb + wc*vc + 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] gen(input int kind, input int ln, input int x);
    case (kind)
      0: return 8'($urandom);
      1: return 8'h00;
      2: return 8'hFF;
      default: return 8'(x*37 + ln*11 + 5);
    endcase
  endfunction

  task automatic feed_line(input bit sof, input int kind, input int ln, input int slot);
    for (int x = 0; x < W; x++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_pix   = gen(kind, ln, x);
      in_last  = (x == W-1);
      in_sof   = sof && (x == 0);
      if (slot >= 0) src[slot][x] = in_pix;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; in_sof = 1'b0;
  endtask

  task automatic feed_group(input bit sof, input int kind, input int base);
    for (int s = 0; s < 3; s++) feed_line(sof && s == 0, kind, base + s, s);
    for (int k = 0; k < 5; k++)
      for (int x = 0; x < W; x++) exp_q.push_back(ref_pix(k, src[0][x], src[1][x], src[2][x]));
    repeat (5*HT + 10) @(negedge clk);
  endtask

  task automatic feed_frame(input int k0, input int k1);
    for (int g = 0; g < OL/5; g++) feed_group(g == 0, (g == 0) ? k0 : k1, g*3);
    repeat (PL*HT + 5) @(negedge clk);
  endtask

  // Monitor
  bit prev_hs = 0, prev_de = 0, have_vs = 0;
  int since_hs = 0, de_len = 0, lines_since_vs = 0, de_lines = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_vsync) chk(out_hsync, "R6", "vsync outside hsync", 0, 1);
      if (out_hsync && !prev_hs) begin
        since_hs = 0;
        if (out_vsync) begin
          if (have_vs) begin
            chk(lines_since_vs == OL+PL, "R7", "line pulses per frame", lines_since_vs, OL+PL);
            chk(de_lines == OL, "R6", "image lines per frame", de_lines, OL);
          end
          have_vs = 1; lines_since_vs = 1; de_lines = 0;
        end else begin
          lines_since_vs++;
        end
      end else begin
        since_hs++;
      end
      if (out_de && !prev_de) begin
        chk(since_hs == HS+3, "R5", "de offset from hsync", since_hs, HS+3);
        de_lines++;
        de_len = 0;
      end
      if (out_de) begin
        de_len++;
        if (exp_q.size() == 0) chk(0, "R3", "unexpected pixel", out_pix, 0);
        else begin
          logic [14:0] e;
          e = exp_q.pop_front();
          chk(out_pix === e, "R3 R4", "pixel", out_pix, e);
        end
      end
      if (!out_de && prev_de) chk(de_len == W, "R5", "de length", de_len, W);
      prev_hs = out_hsync; prev_de = out_de;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 20000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_de && !out_hsync && !out_vsync, "R1", "outputs in reset",
        {out_de, out_hsync, out_vsync}, 0);
    rst_n = 1'b1;
    mon_on = 1;
    repeat (20) @(negedge clk);
    chk(!out_de && !out_hsync && !out_vsync, "R1", "idle after reset",
        {out_de, out_hsync, out_vsync}, 0);
    // partial group does not start playback (R1, R2)
    feed_line(1'b1, 0, 0, -1);
    feed_line(1'b0, 0, 1, -1);
    repeat (3*HT) @(negedge clk);
    chk(!out_hsync && !out_de, "R2", "two lines give no output", out_hsync, 0);
    // R8: stray lines discarded by start-of-frame
    feed_frame(0, 3);
    // R9 extremes: zeros then ones
    feed_frame(1, 2);
    // R8 again with one stray line under a frame start
    feed_line(1'b1, 0, 0, -1);
    feed_frame(3, 0);
    chk(exp_q.size() == 0, "R3", "pixels left over", exp_q.size(), 0);
    chk(lines_since_vs == OL+PL, "R7", "final frame line pulses", lines_since_vs, OL+PL);
    chk(ref_pix(0, 8'h00, 8'h00, 8'h00) == 15'h0421, "R9", "zero reference", 0, 0);
    chk(ref_pix(2, 8'hFF, 8'hFF, 8'hFF) == 15'h37BD, "R9", "ones reference", 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule